// File: doc/BRIEF.md
# Per-vector interrupt coalescing controller

This block holds the control state of a single interrupt vector. Device logic raises one-cycle event assertions. The block turns them into one-cycle send pulses that go to the message-delivery logic. Sends are limited in three ways. A mask bit can set itself whenever a send goes out. A countdown timer is reloaded on every send and blocks the next send until it runs out. The timer only moves on cycles where a free-running tick input is high. An event that cannot be sent is remembered as pending, and it goes out as soon as both the mask and the timer allow it.

Software reaches the vector through a 32-byte register window with a single-cycle write port and a combinational read port. The window holds a signed 16-bit credit counter. The counter rises by one on every send, and software acknowledges interrupts by writing a count that is subtracted from it. If such a write brings the counter to exactly zero, any pending, unsent event is thrown away. The upper half of the credit word carries two side flags: one unmasks the vector and one restarts the timer. Setting both rearms the vector with a single store.

Top module: `intc_vector`

## Requirements
- R1: After reset the mask reads 1, and the initial timer value, the current timer value, the credit count and mask-on-assert all read 0. No send pulse occurs while the vector stays masked and idle.
- R2: The mask is bit 0 at byte offset 4. While it is 1, no send occurs, and events are held as pending. A write of 0 to the mask sends the held event on the next clock edge.
- R3: When the initial timer value is 0 and the vector is unmasked, every cycle with an event assertion produces a send. `irq_o` is one clock wide and is high in the cycle after the edge that sampled the event.
- R4: The initial timer value is bits 5:0 at byte offset 0, and the other bits of the write are dropped. A send loads the current timer, read at byte offset 16, from the initial value. The current timer then drops by one on each clock edge where `tick_i` is high, and it stops at 0.
- R5: No send occurs while the current timer is nonzero, and events that arrive in that time become pending. On the first edge at which the timer reads 0 with an event pending, the event is sent.
- R6: Mask-on-assert is bit 0 at byte offset 12. When it is 1, each send sets the mask to 1.
- R7: The credit count is bits 15:0 at byte offset 8, in 16-bit two's complement, and bits 31:16 of that word read 0. Each send adds 1. A write to offset 8 subtracts write bits 14:0, and bit 15 is ignored. If a send and a credit write happen in the same cycle, the send is counted first.
- R8: A credit write that leaves the count at exactly 0 discards the pending event. This includes an event asserted in that same cycle, so a later unmask sends nothing.
- R9: In a credit write, bit 16 clears the mask and bit 17 reloads the current timer from the initial value. The clear from bit 16 wins over mask-on-assert when a send happens in the same cycle.
- R10: Writes to offsets 16, 20, 24 and 28, and writes to any address that is not a multiple of 4, change no state. Reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | Event assertion from device logic, one per cycle |
| tick_i | input | 1 | Timer advance strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write byte address within the 32-byte window |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 5 | Read byte address within the window |
| rd_data_o | output | 32 | Read data, combinational from `rd_addr_i` |
| irq_o | output | 1 | One-cycle interrupt send pulse |

## Verification
Event streams are applied in four settings: back to back with coalescing off, in bursts while masked, in bursts while the timer runs with and without ticks, and during credit writes. Each setting shows a different gate acting alone: the mask, the timer, or the credit-zero discard. Same-cycle collisions get their own patterns, such as send plus subtraction and send plus unmask under mask-on-assert. These show whether the ordering of send before write is kept. A rotating read address follows every register through each scenario, so stray writes to read-only or reserved offsets and to unaligned addresses show up as wrong read data.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_INIT = 5'd0;
  localparam logic [ADDR_W-1:0] OFS_MASK = 5'd4;
  localparam logic [ADDR_W-1:0] OFS_CRED = 5'd8;
  localparam logic [ADDR_W-1:0] OFS_MOA  = 5'd12;
  localparam logic [ADDR_W-1:0] OFS_CUR  = 5'd16;

  localparam int BIT_UNMASK  = 16;
  localparam int BIT_TRELOAD = 17;

  typedef struct packed {
    logic init;
    logic mask;
    logic cred;
    logic moa;
  } wr_sel_t;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int TMR_W = 6,
  parameter int CNT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              send_i,
  output logic [TMR_W-1:0]  init_o,
  output logic              mask_o,
  output logic              moa_o,
  output logic              cred_wr_o,
  output logic [CNT_W-1:0]  cred_dec_o,
  output logic              unmask_o,
  output logic              treload_o
);
  wr_sel_t          sel;
  logic [TMR_W-1:0] init_q;
  logic             mask_q;
  logic             moa_q;
  logic             wr_mask;
  logic             unused_bits;

  // Ordering: a send applies first, then the software write.
  function automatic logic mask_next(input logic cur, input logic send,
                                     input logic moa, input logic wr,
                                     input logic wval, input logic unmask);
    logic m;
    m = cur;
    if (send && moa) m = 1'b1;
    if (wr)          m = wval;
    if (unmask)      m = 1'b0;
    return m;
  endfunction

  always_comb begin
    sel.init = wr_en_i && (wr_addr_i == OFS_INIT);
    sel.mask = wr_en_i && (wr_addr_i == OFS_MASK);
    sel.cred = wr_en_i && (wr_addr_i == OFS_CRED);
    sel.moa  = wr_en_i && (wr_addr_i == OFS_MOA);
  end

  assign wr_mask     = sel.mask;
  assign cred_wr_o   = sel.cred;
  assign cred_dec_o  = wr_data_i[CNT_W-1:0];
  assign unmask_o    = sel.cred && wr_data_i[BIT_UNMASK];
  assign treload_o   = sel.cred && wr_data_i[BIT_TRELOAD];
  assign unused_bits = ^wr_data_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= '0;
      mask_q <= 1'b1;
      moa_q  <= 1'b0;
    end else begin
      if (sel.init) init_q <= wr_data_i[TMR_W-1:0];
      if (sel.moa)  moa_q  <= wr_data_i[0];
      mask_q <= mask_next(mask_q, send_i, moa_q, wr_mask, wr_data_i[0], unmask_o);
    end
  end

  assign init_o = init_q;
  assign mask_o = mask_q;
  assign moa_o  = moa_q;

  // R6
  moa_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send_i && moa_q && !wr_mask && !unmask_o) |=> mask_q);

  // R9
  unmask_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_o |=> !mask_q);
endmodule

// File: rtl/intc_timer.sv
module intc_timer #(
  parameter int TMR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [TMR_W-1:0] init_i,
  output logic [TMR_W-1:0] cur_o,
  output logic             zero_o
);
  logic [TMR_W-1:0] cur_q;

  function automatic logic [TMR_W-1:0] tmr_step(input logic [TMR_W-1:0] cur,
                                                 input logic tick, input logic load,
                                                 input logic [TMR_W-1:0] init);
    if (load)                      return init;
    else if (tick && cur != '0)    return cur - TMR_W'(1);
    else                           return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= tmr_step(cur_q, tick_i, load_i, init_i);
  end

  assign cur_o  = cur_q;
  assign zero_o = (cur_q == '0);

  // R4
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cur_q == $past(init_i)));

  // R4
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(cur_q));
endmodule

// File: rtl/intc_credit.sv
module intc_credit #(
  parameter int CRED_W = 16,
  parameter int CNT_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              dec_en_i,
  input  logic [CNT_W-1:0]  dec_i,
  output logic [CRED_W-1:0] cnt_o,
  output logic              zero_clr_o
);
  logic [CRED_W-1:0] cnt_q;
  logic [CRED_W-1:0] cnt_nxt;

  // Send is counted before the software subtraction.
  function automatic logic [CRED_W-1:0] credit_next(input logic [CRED_W-1:0] cnt,
                                                    input logic inc, input logic dec_en,
                                                    input logic [CNT_W-1:0] dec);
    logic [CRED_W-1:0] v;
    v = cnt + CRED_W'(inc);
    if (dec_en) v = v - CRED_W'(dec);
    return v;
  endfunction

  assign cnt_nxt    = credit_next(cnt_q, inc_i, dec_en_i, dec_i);
  assign zero_clr_o = dec_en_i && (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;

  // R7
  send_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !dec_en_i) |=> ((cnt_q - $past(cnt_q)) == CRED_W'(1)));
endmodule

// File: rtl/intc_vector.sv
module intc_vector
  import intc_pkg::*;
#(
  parameter int TMR_W  = 6,
  parameter int CRED_W = 16,
  parameter int CNT_W  = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt_i,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic [4:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic [4:0]  rd_addr_i,
  output logic [31:0] rd_data_o,
  output logic        irq_o
);
  logic [TMR_W-1:0]  coal_init;
  logic              mask_q;
  logic              moa_q;
  logic              cred_wr;
  logic [CNT_W-1:0]  cred_dec;
  logic              unmask_req;
  logic              treload_req;
  logic [TMR_W-1:0]  tmr_cur;
  logic              tmr_zero;
  logic              tmr_load;
  logic [CRED_W-1:0] cred_cnt;
  logic              cred_zero_clr;
  logic              send;
  logic              pend_q;
  logic              irq_q;

  intc_regs #(.TMR_W(TMR_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .send_i     (send),
    .init_o     (coal_init),
    .mask_o     (mask_q),
    .moa_o      (moa_q),
    .cred_wr_o  (cred_wr),
    .cred_dec_o (cred_dec),
    .unmask_o   (unmask_req),
    .treload_o  (treload_req)
  );

  assign send     = !mask_q && tmr_zero && (pend_q || evt_i);
  assign tmr_load = send || treload_req;

  intc_timer #(.TMR_W(TMR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .load_i (tmr_load),
    .init_i (coal_init),
    .cur_o  (tmr_cur),
    .zero_o (tmr_zero)
  );

  intc_credit #(.CRED_W(CRED_W), .CNT_W(CNT_W)) u_credit (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_i      (send),
    .dec_en_i   (cred_wr),
    .dec_i      (cred_dec),
    .cnt_o      (cred_cnt),
    .zero_clr_o (cred_zero_clr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= send;
      if (cred_zero_clr || send) pend_q <= 1'b0;
      else if (evt_i)            pend_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    case (rd_addr_i)
      OFS_INIT: rd_data_o = 32'(coal_init);
      OFS_MASK: rd_data_o = 32'(mask_q);
      OFS_CRED: rd_data_o = 32'(cred_cnt);
      OFS_MOA:  rd_data_o = 32'(moa_q);
      OFS_CUR:  rd_data_o = 32'(tmr_cur);
      default:  rd_data_o = '0;
    endcase
  end

  // R2
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |=> !irq_o);

  // R5
  timer_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_zero |=> !irq_o);

  // R8
  credit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cred_zero_clr |=> !pend_q);

  // R3
  send_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !mask_q && tmr_zero) |=> irq_o);
endmodule

// File: tb/tb_intc_vector.sv
module tb_intc_vector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int    n_chk = 0;
  int    n_err = 0;
  int    irq_seen = 0;
  bit    run = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int          m_mask, m_init, m_moa, m_cur, m_pend;
  logic [15:0] m_cred;
  bit          m_irq;

  always #4 clk = ~clk;

  intc_vector dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  always @(posedge clk) begin
    bit s;
    if (!rst_n) begin
      m_mask = 1; m_init = 0; m_moa = 0; m_cur = 0; m_pend = 0; m_cred = 0; m_irq = 0;
    end else begin
      s = (m_mask == 0) && (m_cur == 0) && (m_pend != 0 || evt);
      m_irq = s;
      if (s) begin
        m_cur = m_init; m_cred = m_cred + 16'd1; m_pend = 0;
        if (m_moa != 0) m_mask = 1;
      end else begin
        if (evt) m_pend = 1;
        if (tick && m_cur > 0) m_cur = m_cur - 1;
      end
      if (wr_en) begin
        case (wr_addr)
          5'd0:  m_init = int'(wr_data) & 63;
          5'd4:  m_mask = int'(wr_data) & 1;
          5'd12: m_moa  = int'(wr_data) & 1;
          5'd8: begin
            m_cred = m_cred - {1'b0, wr_data[14:0]};
            if (m_cred == 16'd0) m_pend = 0;
            if (wr_data[16]) m_mask = 0;
            if (wr_data[17]) m_cur = m_init;
          end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    case (a)
      5'd0:    return 32'(m_init);
      5'd4:    return 32'(m_mask);
      5'd8:    return {16'd0, m_cred};
      5'd12:   return 32'(m_moa);
      5'd16:   return 32'(m_cur);
      default: return 32'd0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && run) begin
      n_chk++;
      if (irq !== m_irq) begin
        n_err++;
        $display("FAIL %s irq_o: actual=%0b expected=%0b at %0t", cur_req, irq, m_irq, $time);
      end
      n_chk++;
      if (rd_data !== exp_rd(rd_addr)) begin
        n_err++;
        $display("FAIL %s rd[%0d]: actual=%h expected=%h at %0t", cur_req, rd_addr, rd_data,
                 exp_rd(rd_addr), $time);
      end
      if (irq) irq_seen++;
    end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s count: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit e, input bit t);
    wr_en = 0; evt = e; tick = t; rd_addr = rd_addr + 5'd4;
    @(negedge clk); #1;
  endtask

  task automatic cyc_rd(input logic [4:0] a);
    wr_en = 0; evt = 0; tick = 0; rd_addr = a;
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input bit e, input bit t);
    wr_en = 1; wr_addr = a; wr_data = d; evt = e; tick = t; rd_addr = rd_addr + 5'd4;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1; rst_n = 1; run = 1;

    cur_req = "R1"; idle(8);

    // R2: held while masked, released by unmask
    cur_req = "R2"; irq_seen = 0;
    cyc(1, 0); cyc(0, 0); cyc(1, 0); idle(2);
    wr(5'd4, 32'd0, 0, 0); idle(2);
    check_eq("R2", irq_seen, 1);

    // R3: coalescing off, back-to-back events
    cur_req = "R3"; irq_seen = 0;
    repeat (4) cyc(1, 0);
    idle(2);
    check_eq("R3", irq_seen, 4);

    // R4: load and tick-driven countdown, 6-bit field
    cur_req = "R4";
    wr(5'd0, 32'hFFFF_FFC3, 0, 0);
    cyc(1, 0); idle(3);
    repeat (3) cyc(0, 1);
    idle(2);
    wr(5'd0, 32'h0000_007F, 0, 0);
    cyc(1, 0);
    for (int i = 0; i < 140; i++) cyc(0, i[0]);

    // R5: events during countdown stay pending
    cur_req = "R5"; irq_seen = 0;
    wr(5'd0, 32'd5, 0, 0);
    cyc(1, 0); cyc(1, 1); cyc(1, 1);
    repeat (4) cyc(0, 1);
    idle(2);
    check_eq("R5", irq_seen, 2);
    repeat (6) cyc(0, 1);

    // R6: mask-on-assert
    cur_req = "R6"; irq_seen = 0;
    wr(5'd0, 32'd0, 0, 0);
    wr(5'd12, 32'd1, 0, 0);
    cyc(1, 0); cyc(1, 0); idle(2);
    wr(5'd8, 32'h0001_0000, 0, 0); idle(2);
    check_eq("R6", irq_seen, 2);

    // R8: credit to zero discards pending, incl. same-cycle event
    cur_req = "R8";
    cyc(1, 0);
    wr(5'd8, {17'd0, m_cred[14:0]}, 1, 0);
    irq_seen = 0;
    wr(5'd4, 32'd0, 0, 0); idle(3);
    check_eq("R8", irq_seen, 0);

    // R7: signed credits, send-before-subtract
    cur_req = "R7";
    wr(5'd12, 32'd0, 0, 0);
    wr(5'd8, 32'h0000_7FFF, 0, 0);
    cyc(1, 0);
    wr(5'd8, 32'd3, 1, 0);
    wr(5'd8, 32'h0000_8005, 0, 0);
    idle(6);

    // R9: timer reload flag, unmask beats mask-on-assert
    cur_req = "R9";
    wr(5'd0, 32'd10, 0, 0);
    wr(5'd12, 32'd1, 0, 0);
    cyc(1, 0);
    repeat (3) cyc(0, 1);
    wr(5'd8, 32'h0002_0000, 0, 0);
    idle(5);
    wr(5'd0, 32'd0, 0, 0);
    wr(5'd8, 32'h0002_0000, 0, 0);
    wr(5'd4, 32'd0, 1, 0);
    irq_seen = 0;
    wr(5'd8, 32'h0001_0000, 0, 0);
    cyc(1, 0); idle(5);
    check_eq("R9", irq_seen, 2);

    // R10: read-only, reserved, unaligned accesses
    cur_req = "R10";
    wr(5'd16, 32'h15, 0, 0);
    wr(5'd20, 32'hFFFF_FFFF, 0, 0);
    wr(5'd24, 32'hFFFF_FFFF, 0, 0);
    wr(5'd28, 32'hFFFF_FFFF, 0, 0);
    wr(5'd1, 32'h3F, 0, 0);
    wr(5'd6, 32'h0, 0, 0);
    wr(5'd9, 32'h0003_0001, 0, 0);
    cyc_rd(5'd9);
    idle(8);
    cyc_rd(5'd0);
    idle(8);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule